// File: doc/BRIEF.md
# Tuner Synthesizer Serial Control Interface

This block is a two-wire serial (I2C) slave that holds the digital control state of a tuner's frequency synthesizer. A bus controller writes a 15-bit divider word, a 7-bit control word and a 3-bit band-select word. It reads back one status byte that reports a power-on flag, the loop-lock flag, the automatic charge-pump flag and a 3-bit converter code. The 7-bit slave address is five fixed bits `11000` followed by two bits taken from a strap input. This lets four of these blocks share one bus.

SCL and SDA are sampled into the system clock domain, and their edges are found there. The bus-facing machine `tuner_link_fsm` has these states: `S_IDLE` (no transfer), `S_ADDR` (shifting the address byte), `S_ADDR_ACK` (address matched, waiting to pull SDA low), `S_ACK_HOLD` (holding the acknowledge for one SCL high phase), `S_WR_BYTE` (shifting a data byte in), `S_WR_ACK` (data byte complete, waiting to acknowledge), `S_RD_BYTE` (shifting the status byte out), `S_RD_REL` (releasing SDA after the eighth read bit), `S_RD_ACK` (sampling the controller's acknowledge), `S_RD_LOAD` (controller acknowledged, waiting to send the next byte) and `S_IGNORE` (bus ignored until the next START). A START moves any state to `S_ADDR`. A STOP moves any state to `S_IDLE`. The other transitions happen on SCL edges:

| From | Event | To |
|---|---|---|
| `S_ADDR` | eighth rise | `S_ADDR_ACK` on a match, otherwise `S_IGNORE` |
| `S_ADDR_ACK` | fall | `S_ACK_HOLD` |
| `S_ACK_HOLD` | fall | `S_RD_BYTE` for a read, `S_WR_BYTE` for a write |
| `S_WR_BYTE` | eighth rise | `S_WR_ACK` |
| `S_WR_ACK` | fall | `S_ACK_HOLD` |
| `S_RD_BYTE` | eighth rise | `S_RD_REL` |
| `S_RD_REL` | fall | `S_RD_ACK` |
| `S_RD_ACK` | rise | `S_RD_LOAD` on SDA low, `S_IGNORE` on SDA high |
| `S_RD_LOAD` | fall | `S_RD_BYTE` |

Received bytes go to `tuner_reg_bank`, whose sequencer has three states. `SEQ_SEL` routes a byte by its top bit: 0 means the upper divider byte is stored in a holding register and the sequencer goes to `SEQ_DB2`; 1 means the control word is loaded and the sequencer goes to `SEQ_BB`. `SEQ_DB2` writes the full divider word and returns to `SEQ_SEL`. `SEQ_BB` writes the band word and returns to `SEQ_SEL`. Every START resets the sequencer to `SEQ_SEL`.

Top module: `tuner_ctl_i2c`

## Requirements
- R1: The slave acknowledges (pulls SDA low in the ninth bit) only an address byte whose upper seven bits equal {1,1,0,0,0,addr_sel[1],addr_sel[0]}. Bit 0 of that byte is the read (1) or write (0) flag. Any other address gets no acknowledge.
- R2: In a write, the first data byte is routed by its bit 7. A 0 makes it the upper divider byte; a 1 makes it the control byte. The same rule applies to any byte that follows a completed divider pair or band byte.
- R3: The upper divider byte (bits 6:0 = divider bits 14:8) is held aside. `freq_word` changes only once the following byte (divider bits 7:0) has been fully received. An upper divider byte followed by STOP leaves `freq_word` unchanged.
- R4: A control byte loads its bits 6:0 into `ctrl_word` in the same order: bit 6 pump current select, bits 5:3 test mode, bit 2 and bit 1 reference-ratio selects, bit 0 tuning-output disable.
- R5: The byte that follows a control byte in the same transfer is the band byte. Its bits 2:0 load `band_word` as {low VHF, high VHF, UHF} enables, and its bits 7:3 are ignored.
- R6: A single transfer of address plus four data bytes (upper divider, lower divider, control, band) updates all three registers, and every byte is acknowledged.
- R7: After reset `freq_word` = 0, `ctrl_word` = 7'h4B (pump high, test 001, ratio selects 0 and 1, tuning output off), `band_word` = 0, and the power-on flag is 1.
- R8: A read returns the status byte MSB first as {power-on flag, lock_i, acp_i, 1, 1, adc_code[2:0]}. SDA changes only while SCL is low.
- R9: If the controller acknowledges a read byte, another status byte follows. If it does not, the slave releases SDA and drives nothing until the next START.
- R10: The power-on flag is cleared only when a read ends with no acknowledge from the controller. Writes leave it set.
- R11: A START in the middle of a byte abandons the transfer with all registers unchanged, and the new transfer after it is handled normally.
- R12: After an address that does not match, data bytes on the bus are neither acknowledged nor loaded until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on state) |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| addr_sel | input | 2 | Two strap-selected low address bits |
| lock_i | input | 1 | Loop-lock flag for the status byte |
| acp_i | input | 1 | Automatic charge-pump flag for the status byte |
| adc_code | input | 3 | Converter code for the status byte |
| freq_word | output | 15 | Programmable divider word |
| ctrl_word | output | 7 | Control word (pump, test, ratio, tuning off) |
| band_word | output | 3 | Band enables {low VHF, high VHF, UHF} |

## Verification
The bench sends the upper divider byte on its own and then STOPs. A design that loaded divider bits early would show a half-updated `freq_word` at that point. A byte with bit 7 set that follows a completed divider pair must reach the control register. A sequencer that counted byte positions instead of reading bit 7 would send it to the wrong register. The bench also cuts a control byte short with a repeated START, and addresses a different strap value. A design that acted on partial bytes, or went on listening after a foreign address, would then change `ctrl_word` or acknowledge. Status reads check the power-on flag before and after a read that ends with no acknowledge, and check the repeated byte after an acknowledge. This catches a flag cleared by writes, or a slave that keeps holding SDA after the controller has finished.

// File: rtl/tuner_ctl_pkg.sv
package tuner_ctl_pkg;

    localparam int FREQ_W = 15;
    localparam int CTRL_W = 7;
    localparam int BAND_W = 3;
    localparam int ADC_W  = 3;
    localparam int BYTE_W = 8;

    localparam logic [4:0]        ADDR_FIXED = 5'b11000;
    // pump high, test 001, ratio selects 0/1, tuning output off
    localparam logic [CTRL_W-1:0] CTRL_RST   = 7'b1_001_0_1_1;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_ACK_HOLD,
        S_WR_BYTE,
        S_WR_ACK,
        S_RD_BYTE,
        S_RD_REL,
        S_RD_ACK,
        S_RD_LOAD,
        S_IGNORE
    } link_state_t;

    typedef enum logic [1:0] {
        SEQ_SEL,
        SEQ_DB2,
        SEQ_BB
    } seq_state_t;

endpackage

// File: rtl/tuner_bus_sync.sv
module tuner_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/tuner_link_fsm.sv
module tuner_link_fsm
    import tuner_ctl_pkg::*;
#(
    parameter int          ADC_BITS  = ADC_W,
    parameter logic [4:0]  FIXED_HI  = ADDR_FIXED
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sda_s,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic [1:0]          addr_sel,
    input  logic                por_flag,
    input  logic                lock_i,
    input  logic                acp_i,
    input  logic [ADC_BITS-1:0] adc_code,
    output logic                sda_oe,
    output logic                byte_vld,
    output logic [BYTE_W-1:0]   byte_dat,
    output logic                por_clr
);

    localparam int CNT_W = $clog2(BYTE_W);

    link_state_t        state;
    link_state_t        nxt;
    logic [CNT_W-1:0]   bitcnt;
    logic [BYTE_W-1:0]  shreg;
    logic [BYTE_W-1:0]  txreg;
    logic               rw_q;
    logic               bit_last;
    logic [BYTE_W-1:0]  rx_full;
    logic               addr_hit;
    logic [BYTE_W-1:0]  status;
    logic               tx_load;

    assign bit_last = (bitcnt == CNT_W'(BYTE_W - 1));
    assign rx_full  = {shreg[BYTE_W-2:0], sda_s};
    assign addr_hit = (rx_full[BYTE_W-1:1] == {FIXED_HI, addr_sel});
    assign status   = {por_flag, lock_i, acp_i, 2'b11, adc_code};
    assign tx_load  = (nxt == S_RD_BYTE) && (state != S_RD_BYTE);
    assign byte_dat = shreg;

    // next-state logic
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = S_ADDR;
        end else if (stop_det) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:     nxt = S_IDLE;
                S_ADDR:     if (scl_rise && bit_last) nxt = addr_hit ? S_ADDR_ACK : S_IGNORE;
                S_ADDR_ACK: if (scl_fall) nxt = S_ACK_HOLD;
                S_ACK_HOLD: if (scl_fall) nxt = rw_q ? S_RD_BYTE : S_WR_BYTE;
                S_WR_BYTE:  if (scl_rise && bit_last) nxt = S_WR_ACK;
                S_WR_ACK:   if (scl_fall) nxt = S_ACK_HOLD;
                S_RD_BYTE:  if (scl_rise && bit_last) nxt = S_RD_REL;
                S_RD_REL:   if (scl_fall) nxt = S_RD_ACK;
                S_RD_ACK:   if (scl_rise) nxt = sda_s ? S_IGNORE : S_RD_LOAD;
                S_RD_LOAD:  if (scl_fall) nxt = S_RD_BYTE;
                S_IGNORE:   nxt = S_IGNORE;
                default:    nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            shreg    <= '0;
            txreg    <= '0;
            rw_q     <= 1'b0;
            sda_oe   <= 1'b0;
            byte_vld <= 1'b0;
            por_clr  <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            por_clr  <= 1'b0;
            if (start_det || stop_det) begin
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    S_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= rx_full;
                            bitcnt <= bitcnt + 1'b1;
                            if (bit_last) rw_q <= sda_s;
                        end
                    end
                    S_WR_BYTE: begin
                        if (scl_rise) begin
                            shreg  <= rx_full;
                            bitcnt <= bitcnt + 1'b1;
                            if (bit_last) byte_vld <= 1'b1;
                        end
                    end
                    S_ADDR_ACK, S_WR_ACK: begin
                        if (scl_fall) sda_oe <= 1'b1;
                    end
                    S_ACK_HOLD: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                        end
                    end
                    S_RD_BYTE: begin
                        if (scl_rise) bitcnt <= bitcnt + 1'b1;
                        if (scl_fall) begin
                            txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~txreg[BYTE_W-2];
                        end
                    end
                    S_RD_REL: begin
                        if (scl_fall) sda_oe <= 1'b0;
                    end
                    S_RD_ACK: begin
                        if (scl_rise && sda_s) por_clr <= 1'b1;
                    end
                    S_IDLE, S_RD_LOAD, S_IGNORE: begin
                    end
                    default: begin
                    end
                endcase
                if (tx_load) begin
                    txreg  <= status;
                    sda_oe <= ~status[BYTE_W-1];
                    bitcnt <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/tuner_reg_bank.sv
module tuner_reg_bank
    import tuner_ctl_pkg::*;
#(
    parameter int                FREQ_BITS = FREQ_W,
    parameter int                CTRL_BITS = CTRL_W,
    parameter int                BAND_BITS = BAND_W,
    parameter logic [CTRL_W-1:0] CTRL_INIT = CTRL_RST
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic                 byte_vld,
    input  logic [BYTE_W-1:0]    byte_dat,
    input  logic                 por_clr,
    output logic [FREQ_BITS-1:0] freq_word,
    output logic [CTRL_BITS-1:0] ctrl_word,
    output logic [BAND_BITS-1:0] band_word,
    output logic                 por_flag
);

    localparam int HI_W = FREQ_BITS - BYTE_W;

    seq_state_t      seq;
    logic [HI_W-1:0] hi_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq       <= SEQ_SEL;
            hi_hold   <= '0;
            freq_word <= '0;
            ctrl_word <= CTRL_INIT;
            band_word <= '0;
            por_flag  <= 1'b1;
        end else begin
            if (por_clr) por_flag <= 1'b0;
            if (restart) begin
                seq <= SEQ_SEL;
            end else if (byte_vld) begin
                unique case (seq)
                    SEQ_SEL: begin
                        if (byte_dat[BYTE_W-1]) begin
                            ctrl_word <= byte_dat[CTRL_BITS-1:0];
                            seq       <= SEQ_BB;
                        end else begin
                            hi_hold <= byte_dat[HI_W-1:0];
                            seq     <= SEQ_DB2;
                        end
                    end
                    SEQ_DB2: begin
                        freq_word <= {hi_hold, byte_dat};
                        seq       <= SEQ_SEL;
                    end
                    SEQ_BB: begin
                        band_word <= byte_dat[BAND_BITS-1:0];
                        seq       <= SEQ_SEL;
                    end
                    default: seq <= SEQ_SEL;
                endcase
            end
        end
    end

endmodule

// File: rtl/tuner_ctl_i2c.sv
module tuner_ctl_i2c
    import tuner_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        addr_sel,
    input  logic              lock_i,
    input  logic              acp_i,
    input  logic [ADC_W-1:0]  adc_code,
    output logic [FREQ_W-1:0] freq_word,
    output logic [CTRL_W-1:0] ctrl_word,
    output logic [BAND_W-1:0] band_word
);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_dat;
    logic              por_clr;
    logic              por_flag;

    tuner_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tuner_link_fsm u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_sel  (addr_sel),
        .por_flag  (por_flag),
        .lock_i    (lock_i),
        .acp_i     (acp_i),
        .adc_code  (adc_code),
        .sda_oe    (sda_oe),
        .byte_vld  (byte_vld),
        .byte_dat  (byte_dat),
        .por_clr   (por_clr)
    );

    tuner_reg_bank u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (start_det),
        .byte_vld  (byte_vld),
        .byte_dat  (byte_dat),
        .por_clr   (por_clr),
        .freq_word (freq_word),
        .ctrl_word (ctrl_word),
        .band_word (band_word),
        .por_flag  (por_flag)
    );

endmodule

// File: rtl/tuner_ctl_i2c_chk.sv
module tuner_ctl_i2c_chk
    import tuner_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              sda_oe,
    input logic [FREQ_W-1:0] freq_word,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic [BAND_W-1:0] band_word,
    input logic              byte_vld,
    input logic [BYTE_W-1:0] byte_dat,
    input logic              por_flag,
    input logic              por_clr
);

    // R7: power-on values present when reset lifts
    a_r7_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (freq_word == '0 && ctrl_word == CTRL_RST &&
                          band_word == '0 && por_flag));

    // R3: divider word moves only on a completed received byte
    a_r3_freq_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freq_word) |-> $past(byte_vld));

    // R4: control word takes bits 6:0 of a byte whose bit 7 is set
    a_r4_ctrl_from_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_word) |-> ($past(byte_vld) && $past(byte_dat[BYTE_W-1]) &&
                                 ctrl_word == $past(byte_dat[CTRL_W-1:0])));

    // R5: band word takes the low bits of a received byte
    a_r5_band_from_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(band_word) |-> ($past(byte_vld) &&
                                 band_word == $past(byte_dat[BAND_W-1:0])));

    // R10: power-on flag only falls, and only on an end-of-read request
    a_r10_por_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(por_flag) |-> ($fell(por_flag) && $past(por_clr)));

    // R8: SDA drive changes only while the synchronised SCL is low
    a_r8_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

endmodule

bind tuner_ctl_i2c tuner_ctl_i2c_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_oe    (sda_oe),
    .freq_word (freq_word),
    .ctrl_word (ctrl_word),
    .band_word (band_word),
    .byte_vld  (byte_vld),
    .byte_dat  (byte_dat),
    .por_flag  (por_flag),
    .por_clr   (por_clr)
);

// File: tb/tuner_ctl_i2c_test.sv
module tuner_ctl_i2c_test;

    localparam int Q = 10;          // clocks per quarter bit
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [1:0]  addr_sel = 2'b10;
    logic        lock_i = 1'b0;
    logic        acp_i = 1'b1;
    logic [2:0]  adc_code = 3'b000;
    logic        sda_oe;
    logic [14:0] freq_word;
    logic [6:0]  ctrl_word;
    logic [2:0]  band_word;
    logic        sda_line;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    assign sda_line = m_sda & ~sda_oe;

    always #10 clk = ~clk;  // 50 MHz

    tuner_ctl_i2c uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .addr_sel  (addr_sel),
        .lock_i    (lock_i),
        .acp_i     (acp_i),
        .adc_code  (adc_code),
        .freq_word (freq_word),
        .ctrl_word (ctrl_word),
        .band_word (band_word)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(1);
        scl = 1'b1;   wq(1);
        m_sda = 1'b0; wq(1);
        scl = 1'b0;   wq(1);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(1);
        scl = 1'b1;   wq(1);
        m_sda = 1'b1; wq(2);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; wq(1);
        scl = 1'b1; wq(2);
        scl = 1'b0; wq(1);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; wq(1);
        scl = 1'b1; wq(1);
        b = sda_line; wq(1);
        scl = 1'b0; wq(1);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic nack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(nack);
    endtask

    task automatic get_byte(input logic master_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(~master_ack);
    endtask

    task automatic t_reset_state();
        chk("R7 freq reset", freq_word, 15'h0000);
        chk("R7 ctrl reset", ctrl_word, 7'h4B);
        chk("R7 band reset", band_word, 3'b000);
    endtask

    task automatic t_full_write();
        logic n;
        bus_start();
        put_byte(8'hC4, n); chk("R1 own address acked", n, 0);
        put_byte(8'h12, n); chk("R6 divider byte 1 acked", n, 0);
        put_byte(8'h34, n); chk("R6 divider byte 2 acked", n, 0);
        put_byte(8'hA6, n); chk("R6 control byte acked", n, 0);
        put_byte(8'hFD, n); chk("R6 band byte acked", n, 0);
        bus_stop();
        chk("R6 R3 freq after full write", freq_word, 15'h1234);
        chk("R6 R4 ctrl after full write", ctrl_word, 7'h26);
        chk("R5 band low bits only", band_word, 3'b101);
    endtask

    task automatic t_partial_divider();
        logic n;
        bus_start();
        put_byte(8'hC4, n);
        put_byte(8'h05, n);
        bus_stop();
        chk("R3 upper byte alone leaves freq", freq_word, 15'h1234);
        bus_start();
        put_byte(8'hC4, n);
        put_byte(8'h05, n);
        put_byte(8'h67, n);
        bus_stop();
        chk("R3 divider pair loads freq", freq_word, 15'h0567);
    endtask

    task automatic t_control_first();
        logic n;
        bus_start();
        put_byte(8'hC4, n);
        put_byte(8'hC1, n);
        put_byte(8'h02, n);
        bus_stop();
        chk("R2 bit7=1 routes to control", ctrl_word, 7'h41);
        chk("R5 byte after control is band", band_word, 3'b010);
        chk("R2 freq untouched by control write", freq_word, 15'h0567);
        // divider pair then a control byte: routed by bit 7
        bus_start();
        put_byte(8'hC4, n);
        put_byte(8'h01, n);
        put_byte(8'h02, n);
        put_byte(8'h9C, n);
        bus_stop();
        chk("R2 freq from pair", freq_word, 15'h0102);
        chk("R2 byte after pair with bit7=1 is control", ctrl_word, 7'h1C);
    endtask

    task automatic t_foreign_address();
        logic n;
        bus_start();
        put_byte(8'hC6, n); chk("R1 foreign address not acked", n, 1);
        put_byte(8'h81, n); chk("R12 data after foreign address not acked", n, 1);
        put_byte(8'h07, n);
        bus_stop();
        chk("R12 ctrl unchanged", ctrl_word, 7'h1C);
        chk("R12 band unchanged", band_word, 3'b010);
    endtask

    task automatic t_start_abort();
        logic n;
        bus_start();
        put_byte(8'hC4, n);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        chk("R11 ctrl unchanged by cut byte", ctrl_word, 7'h1C);
        put_byte(8'hC4, n); chk("R11 address acked after restart", n, 0);
        put_byte(8'hB3, n);
        bus_stop();
        chk("R11 transfer after restart loads", ctrl_word, 7'h33);
    endtask

    task automatic t_status_read();
        logic       n;
        logic [7:0] v;
        lock_i = 1'b1; acp_i = 1'b0; adc_code = 3'b101;
        bus_start();
        put_byte(8'hC5, n); chk("R1 read address acked", n, 0);
        get_byte(1'b1, v); chk("R8 R10 status with power-on flag set", v, 8'hDD);
        get_byte(1'b0, v); chk("R9 second byte after master ack", v, 8'hDD);
        chk("R9 SDA released after master nack", sda_oe, 0);
        bus_stop();
        lock_i = 1'b0; acp_i = 1'b1; adc_code = 3'b010;
        bus_start();
        put_byte(8'hC5, n);
        get_byte(1'b0, v); chk("R10 power-on flag cleared by read end", v, 8'h3A);
        bus_stop();
        chk("R9 no drive after read end", sda_oe, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        wq(2);
        t_reset_state();
        t_full_write();
        t_partial_divider();
        t_control_first();
        t_foreign_address();
        t_start_abort();
        t_status_read();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule